// File: doc/BRIEF.md
# Clocked Pulse-Width Phase Subtractor

This block subtracts a digital feedback word from the width of an input pulse, and does it in the time domain. A fast clock samples the input pulse. When the sampled pulse rises, the block captures the feedback word and raises a reference pulse. The reference pulse stays high for exactly that many clock ticks and then clears. Two comparison outputs follow. One is high while the input is high and the reference is not. The other is high while the reference is high and the input is not. The difference is therefore carried as two pulse streams, each of a single sign, and never as a signed number.

A typical user is a noise-shaping time-to-digital loop. That loop feeds a quantized code back and wants the remaining time error as a pulse, so that a downstream time integrator or gated-oscillator quantizer can process it. At start-up the feedback is zero, so the first positive pulse covers the whole input width. The reference pulse is also brought out for observation.

Top module: `psub_phase_sub`

## Requirements
- R1: While rst_ni is low and just after it is released, ref_o, pos_o and neg_o are all 0.
- R2: The block raises ref_o in the clock cycle after the first clock edge that samples pulse_i high following a low sample, provided fb_i is nonzero at that edge. ref_o then stays high for exactly fb_i cycles.
- R3: The block takes fb_i only at the edge that starts the reference pulse. Changes to fb_i while ref_o is high do not change the length of that pulse.
- R4: pos_o is high exactly when the registered input pulse (pulse_i delayed one cycle) is high and ref_o is low.
- R5: neg_o is high exactly when the registered input pulse is low and ref_o is high.
- R6: A rising edge taken with fb_i equal to 0 does not raise ref_o. neg_o stays low, and pos_o is high for the full input width.
- R7: For an isolated pulse of width W cycles taken with feedback F, the high cycles of pos_o minus the high cycles of neg_o equal W minus F. pos_o covers max(W-F,0) cycles and neg_o covers max(F-W,0) cycles.
- R8: A rising edge of pulse_i that arrives while ref_o is high is ignored. The reference pulse neither restarts nor stretches.
- R9: pos_o responds to pulse_i one clock cycle later. It stays 0 in the cycle in which pulse_i first goes high and becomes 1 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pulse_i | input | 1 | Input pulse to be measured |
| fb_i | input | FB_W (10) | Unsigned feedback word, in clock ticks |
| ref_o | output | 1 | Reference pulse built from the captured feedback |
| pos_o | output | 1 | Positive difference pulse |
| neg_o | output | 1 | Negative difference pulse |

## Verification
On every cycle the assertions check four things. Each reference pulse starts only on a sampled input rise and ends after exactly the captured feedback count. Each difference output is high only with the correct levels of the input and the reference. A rise taken with zero feedback never raises the reference. Whether feedback changes or a second rise during a busy reference are really ignored, and whether the per-pulse count balance of R7 holds, shows only in the bench scenarios. These run over pulse widths shorter than, equal to and longer than the feedback, up to the largest 10-bit word. The one-cycle output latency and the reset state are also checked only by directed bench tests.

// File: rtl/psub_pkg.sv
package psub_pkg;
  localparam int unsigned FB_W_DEF = 10;

  typedef struct packed {
    logic pos;
    logic neg;
  } diff_t;
endpackage

// File: rtl/psub_edge.sv
module psub_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic in_q_o,
  output logic rise_o
);
  logic in_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_q <= 1'b0;
    else         in_q <= pulse_i;
  end

  assign in_q_o = in_q;
  assign rise_o = pulse_i & ~in_q;
endmodule

// File: rtl/psub_width.sv
module psub_width #(
  parameter int unsigned FB_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rise_i,
  input  logic [FB_W-1:0] fb_i,
  output logic            ref_o
);
  localparam logic [FB_W-1:0] ONE = {{(FB_W-1){1'b0}}, 1'b1};

  logic            ref_q;
  logic [FB_W-1:0] cnt_q;

  // set/reset latch: rise sets, terminal count clears; busy ignores new rises
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= 1'b0;
      cnt_q <= '0;
    end else if (ref_q) begin
      if (cnt_q == '0) ref_q <= 1'b0;
      else             cnt_q <= cnt_q - ONE;
    end else if (rise_i && (fb_i != '0)) begin
      ref_q <= 1'b1;
      cnt_q <= fb_i - ONE;
    end
  end

  assign ref_o = ref_q;
endmodule

// File: rtl/psub_cmp.sv
module psub_cmp
  import psub_pkg::*;
(
  input  logic  in_i,
  input  logic  ref_i,
  output diff_t diff_o
);
  always_comb begin
    diff_o.pos = in_i & ~ref_i;
    diff_o.neg = ~in_i & ref_i;
  end
endmodule

// File: rtl/psub_phase_sub.sv
module psub_phase_sub
  import psub_pkg::*;
#(
  parameter int unsigned FB_W = FB_W_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pulse_i,
  input  logic [FB_W-1:0] fb_i,
  output logic            ref_o,
  output logic            pos_o,
  output logic            neg_o
);
  logic  in_q;
  logic  rise;
  logic  ref_w;
  diff_t diff;

  psub_edge i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pulse_i(pulse_i),
    .in_q_o (in_q),
    .rise_o (rise)
  );

  psub_width #(.FB_W(FB_W)) i_width (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rise_i(rise),
    .fb_i  (fb_i),
    .ref_o (ref_w)
  );

  psub_cmp i_cmp (
    .in_i  (in_q),
    .ref_i (ref_w),
    .diff_o(diff)
  );

  assign ref_o = ref_w;
  assign pos_o = diff.pos;
  assign neg_o = diff.neg;
endmodule

// File: rtl/psub_phase_sub_chk.sv
module psub_phase_sub_chk #(
  parameter int unsigned FB_W = 10
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            pulse_i,
  input logic [FB_W-1:0] fb_i,
  input logic            ref_o,
  input logic            pos_o,
  input logic            neg_o
);
  logic [FB_W-1:0] fb_d;
  logic [FB_W-1:0] cap;
  logic [FB_W:0]   len;
  logic            ref_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fb_d  <= '0;
      cap   <= '0;
      len   <= '0;
      ref_d <= 1'b0;
    end else begin
      fb_d  <= fb_i;
      ref_d <= ref_o;
      len   <= ref_o ? len + 1'b1 : '0;
      if (ref_o && !ref_d) cap <= fb_d;
      if (ref_d && !ref_o)
        AST_REF_LEN: assert (len == {1'b0, cap}) else $error("ref length"); // R3
    end
  end

  AST_REF_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ref_o) |-> $past(pulse_i)) else $error("ref start"); // R2

  AST_POS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_o |-> ($past(pulse_i) && !ref_o)) else $error("pos source"); // R4

  AST_NEG_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    neg_o |-> (!$past(pulse_i) && ref_o)) else $error("neg source"); // R5

  AST_ZERO_FB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && !$past(pulse_i) && !ref_o && (fb_i == '0)) |=> !ref_o)
    else $error("zero fb"); // R6

  AST_ONE_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({pos_o, neg_o}) <= 1) else $error("both signs"); // R7
endmodule

bind psub_phase_sub psub_phase_sub_chk #(.FB_W(FB_W)) i_chk (.*);

// File: tb/test_psub_phase_sub.sv
module test_psub_phase_sub;
  localparam int FB_W = 10;
  localparam int NV   = 8;
  // {width, fb, expected pos cycles, expected neg cycles}
  localparam int VEC [NV][4] = '{
    '{8, 3, 5, 0}, '{5, 5, 0, 0}, '{4, 9, 0, 5}, '{10, 0, 10, 0},
    '{1, 1, 0, 0}, '{1, 6, 0, 5}, '{20, 7, 13, 0}, '{3, 1023, 0, 1020}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            pulse = 1'b0;
  logic [FB_W-1:0] fb = '0;
  logic            ref_w, pos_w, neg_w;
  int n_chk = 0, n_fail = 0;
  int pos_cnt = 0, neg_cnt = 0, ref_cnt = 0;

  always #4 clk = ~clk;

  psub_phase_sub #(.FB_W(FB_W)) i_psub_phase_sub (
    .clk_i(clk), .rst_ni(rst_n), .pulse_i(pulse), .fb_i(fb),
    .ref_o(ref_w), .pos_o(pos_w), .neg_o(neg_w)
  );

  always @(negedge clk) if (rst_n) begin
    pos_cnt <= pos_cnt + int'(pos_w);
    neg_cnt <= neg_cnt + int'(neg_w);
    ref_cnt <= ref_cnt + int'(ref_w);
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic run_pulse(input int w, input int f, input int gap,
                           output int dp, output int dn, output int dr);
    int p0, n0, r0;
    p0 = pos_cnt; n0 = neg_cnt; r0 = ref_cnt;
    fb = FB_W'(f);
    pulse = 1'b1;
    step(w);
    pulse = 1'b0;
    step(gap);
    dp = pos_cnt - p0; dn = neg_cnt - n0; dr = ref_cnt - r0;
  endtask

  task automatic run_all;
    int dp, dn, dr, p0, n0, r0;
    step(3);
    chk("R1 ref", int'(ref_w), 0);
    chk("R1 pos", int'(pos_w), 0);
    chk("R1 neg", int'(neg_w), 0);
    rst_n = 1'b1;
    step(2);
    chk("R1 after release", int'({ref_w, pos_w, neg_w}), 0);

    for (int i = 0; i < NV; i++) begin
      run_pulse(VEC[i][0], VEC[i][1], VEC[i][1] + 4, dp, dn, dr);
      chk("R4 pos count", dp, VEC[i][2]);
      chk("R5 neg count", dn, VEC[i][3]);
      chk("R7 balance", dp - dn, VEC[i][0] - VEC[i][1]);
      chk(VEC[i][1] == 0 ? "R6 ref count" : "R2 ref count", dr, VEC[i][1]);
    end

    // R3: fb changes after capture
    p0 = pos_cnt; r0 = ref_cnt;
    fb = 10'd4; pulse = 1'b1;
    step(1);
    fb = 10'd9;
    step(11);
    pulse = 1'b0;
    step(14);
    chk("R3 ref count", ref_cnt - r0, 4);
    chk("R3 pos count", pos_cnt - p0, 8);

    // R8: second rise while reference busy
    p0 = pos_cnt; n0 = neg_cnt; r0 = ref_cnt;
    fb = 10'd10; pulse = 1'b1; step(2);
    pulse = 1'b0; step(2);
    pulse = 1'b1; step(2);
    pulse = 1'b0; step(14);
    chk("R8 ref count", ref_cnt - r0, 10);
    chk("R8 pos count", pos_cnt - p0, 0);
    chk("R8 neg count", neg_cnt - n0, 6);

    // R9: one-cycle latency, fb zero
    fb = '0; pulse = 1'b1;
    @(negedge clk);
    chk("R9 pos before edge", int'(pos_w), 0);
    @(negedge clk);
    chk("R9 pos after edge", int'(pos_w), 1);
    chk("R6 neg with zero fb", int'(neg_w), 0);
    step(1);
    pulse = 1'b0;
    step(4);
  endtask

  initial begin
    fork
      run_all;
      begin
        repeat (150000) @(posedge clk);
        chk("watchdog", 1, 0);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule